// File: doc/BRIEF.md
# Asynchronous-Acknowledge Burst Bus Master

This block sequences multi-beat burst transfers from an on-chip requester onto a narrow external port. On such a port the slave ends each data beat with an acknowledge that is not related to the bus clock. A request names the direction, a supervisor flag, a starting low address and a beat count. While idle, the block accepts the request and opens the transfer with a one-clock start strobe. From the second clock it drives the supervisor marker. It then walks the two low address bits upward, one step per completed beat.

The acknowledge is first captured on a falling clock edge and then retimed on the next rising edge. Every beat waits for this retimed copy. If the slave acknowledges before the falling edge of the clock ahead of a sampling clock, the beat completes at the end of that sampling clock with no wait. The first beat samples in the third clock of the transfer. Each following beat samples two clocks after the previous one.

For reads, each beat's port data is packed into a line register. For writes, each beat's slice of the supplied line is driven until that beat is acknowledged. When the last beat completes, a one-clock done pulse is raised and the assembled line is presented.

Top module: `async_burst_master`

## Requirements
- R1: `bus_ts` is high for exactly the first clock of a transfer. `bus_act` is high from that clock through the clock in which the final beat is acknowledged.
- R2: `bus_tm` is low in the start clock. For the rest of the transfer it equals the supervisor flag latched from `req_super`.
- R3: The acknowledge is captured on the falling clock edge and retimed on the rising edge. If `bus_ack` rises after the edge that opens clock k and falls after the next rising edge, the beat completes at the end of clock k+1, and not earlier. With no waits, the first beat samples in clock 3 and each later beat samples two clocks after the previous one.
- R4: While the retimed acknowledge is low in a sampling clock, a wait state is inserted. The address and the write data hold until the acknowledge is seen.
- R5: On a read, the data of beat k is stored at bits [16k+15:16k] of `rd_data`. Bits for beats that were not transferred read zero. A new accepted request clears `rd_data`. `done` is a one-clock pulse in the clock after the final acknowledge, and `bus_act` is low in that clock.
- R6: `bus_addr` equals `req_addr` for the first beat. It increments by one, modulo 4, in the clock after each completed beat that is not the last.
- R7: During a write, `bus_doe` is high for the whole transfer and `bus_dout` carries bits [16k+15:16k] of `req_wdata` for beat k. During a read, `bus_doe` is low and `bus_rd` is high.
- R8: The effective beat count is `req_beats` clamped to the range 2 to 16.
- R9: A request is accepted only while `req_ready` is high. A `req_valid` pulse during a transfer does not alter that transfer and does not start another one.
- R10: Asserting reset abandons a transfer at once. All bus outputs go low, `req_ready` goes high, and the synchronizer stages clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = burst write, 0 = burst read |
| req_super | input | 1 | Supervisor access flag |
| req_beats | input | 5 | Requested beat count (clamped to 2..16) |
| req_addr | input | 2 | Starting low address |
| req_wdata | input | 256 | Write line, beat k in bits [16k+15:16k] |
| req_ready | output | 1 | Sequencer idle |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 256 | Assembled read line |
| bus_ts | output | 1 | Transfer start strobe |
| bus_act | output | 1 | Transfer in progress |
| bus_rd | output | 1 | 1 = read transfer |
| bus_tm | output | 1 | Supervisor marker |
| bus_addr | output | 2 | Low address bits |
| bus_dout | output | 16 | Write data on the port |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 16 | Read data from the port |
| bus_ack | input | 1 | Asynchronous transfer acknowledge, active high |

## Verification
The hardest situation to reach from the ports is the exact edge at which a beat completes. An acknowledge that arrives late in a clock must not finish the beat in the following clock. It must finish it in the clock after that.

The bench slave raises `bus_ack` one time step after a chosen rising edge and drops it after the next edge. This places each acknowledge a known number of clocks after the beat's address clock. The bench then checks that the address has not advanced one clock after the acknowledge and has advanced two clocks after it.

Per-beat wait counts are varied inside a single burst. A 16-beat burst starting at address 3 checks the address wrap. Two more cases are driven: a reset that arrives while the acknowledge is high, and a request pulse while the sequencer is busy.

// File: rtl/async_burst_master.sv
module async_burst_master #(
  parameter int PORT_W    = 16,
  parameter int MAX_BEATS = 16,
  parameter int MIN_BEATS = 2,
  parameter int AW        = 2,
  localparam int BCW      = $clog2(MAX_BEATS + 1),
  localparam int IW       = $clog2(MAX_BEATS),
  localparam int LINE_W   = MAX_BEATS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_super,
  input  logic [BCW-1:0]    req_beats,
  input  logic [AW-1:0]     req_addr,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [LINE_W-1:0] rd_data,
  output logic              bus_ts,
  output logic              bus_act,
  output logic              bus_rd,
  output logic              bus_tm,
  output logic [AW-1:0]     bus_addr,
  output logic [PORT_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [PORT_W-1:0] bus_din,
  input  logic              bus_ack
);

  typedef enum logic [2:0] {S_IDLE, S_C1, S_C2, S_SAMP, S_NEXT} st_t;

  st_t               st;
  logic              ack_f, ack_s;
  logic              wr_q, sup_q;
  logic [IW-1:0]     idx, last_q;
  logic [AW-1:0]     addr_q;
  logic [LINE_W-1:0] wd_q, rd_q;
  logic [BCW-1:0]    eff_beats, eff_m1;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) ack_f <= 1'b0;
    else        ack_f <= bus_ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_s <= 1'b0;
    else        ack_s <= ack_f;

  assign eff_beats = (req_beats < BCW'(MIN_BEATS)) ? BCW'(MIN_BEATS) :
                     (req_beats > BCW'(MAX_BEATS)) ? BCW'(MAX_BEATS) : req_beats;
  assign eff_m1    = eff_beats - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wr_q   <= 1'b0;
      sup_q  <= 1'b0;
      idx    <= '0;
      last_q <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            st     <= S_C1;
            wr_q   <= req_write;
            sup_q  <= req_super;
            idx    <= '0;
            last_q <= eff_m1[IW-1:0];
            addr_q <= req_addr;
            wd_q   <= req_wdata;
            rd_q   <= '0;
          end
        S_C1:   st <= S_C2;
        S_C2:   st <= S_SAMP;
        S_NEXT: st <= S_SAMP;
        S_SAMP:
          if (ack_s) begin
            if (!wr_q) rd_q[idx*PORT_W +: PORT_W] <= bus_din;
            if (idx == last_q) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st     <= S_NEXT;
              idx    <= idx + 1'b1;
              addr_q <= addr_q + 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign bus_act   = (st != S_IDLE);
  assign bus_ts    = (st == S_C1);
  assign bus_tm    = bus_act && !bus_ts && sup_q;
  assign bus_rd    = bus_act && !wr_q;
  assign bus_addr  = bus_act ? addr_q : '0;
  assign bus_doe   = bus_act && wr_q;
  assign bus_dout  = bus_doe ? wd_q[idx*PORT_W +: PORT_W] : '0;
  assign rd_data   = rd_q;

endmodule

module async_burst_master_chk #(
  parameter int PORT_W = 16,
  parameter int AW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              bus_ts,
  input logic              bus_act,
  input logic              bus_tm,
  input logic              bus_doe,
  input logic [AW-1:0]     bus_addr,
  input logic [PORT_W-1:0] bus_dout,
  input logic              ack_s
);

  p_ts_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |=> !bus_ts);

  p_tm_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ts |-> !bus_tm);

  p_step_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && $past(bus_act) && bus_addr != $past(bus_addr)) |-> $past(ack_s));

  p_addr_plus_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && $past(bus_act) && bus_addr != $past(bus_addr))
      |-> bus_addr == AW'($past(bus_addr) + 1'b1));

  p_wdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe && $past(bus_doe) && bus_addr == $past(bus_addr)) |-> $stable(bus_dout));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_act && $past(bus_act)) ##1 !done);

  p_accept_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_act) |-> $past(req_ready));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!bus_act && !bus_ts && !bus_doe && !done && req_ready));

endmodule

bind async_burst_master async_burst_master_chk #(.PORT_W(PORT_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .bus_ts(bus_ts), .bus_act(bus_act), .bus_tm(bus_tm), .bus_doe(bus_doe),
  .bus_addr(bus_addr), .bus_dout(bus_dout), .ack_s(ack_s)
);

// File: tb/async_burst_master_bench.sv
module async_burst_master_bench;
  localparam int PW = 16;
  localparam int LW = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
  logic [4:0] req_beats = 5'd2;
  logic [1:0] req_addr = 2'd0;
  logic [LW-1:0] req_wdata = '0;
  logic req_ready, done, bus_ts, bus_act, bus_rd, bus_tm, bus_doe;
  logic [LW-1:0] rd_data;
  logic [1:0] bus_addr;
  logic [PW-1:0] bus_dout, bus_din = '0;
  logic bus_ack = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [LW-1:0] exp_q[$];

  always #4 clk = ~clk;

  async_burst_master u_async_burst_master (.*);

  task automatic chk(input bit ok, input string tag, input logic [LW-1:0] a, input logic [LW-1:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [PW-1:0] rdv(input int b, input logic [PW-1:0] seed);
    return seed ^ PW'(b * 16'h1357) ^ 16'h8000;
  endfunction

  function automatic int clampn(input int n);
    return n < 2 ? 2 : (n > 16 ? 16 : n);
  endfunction

  always @(negedge clk) if (rst_n && done) begin
    if (exp_q.size() == 0) chk(0, "R5 unexpected done", 1, 0);
    else begin
      logic [LW-1:0] e;
      e = exp_q.pop_front();
      chk(rd_data === e, "R5 assembled line", rd_data, e);
    end
  end

  task automatic beat_chk(input bit wr, input bit sup, input logic [1:0] ea,
                          input int b, input logic [LW-1:0] wd);
    chk(bus_act && !bus_ts, "R1 act high, ts low mid-transfer", {bus_act, bus_ts}, 2'b10);
    chk(bus_tm == sup, "R2 supervisor marker", bus_tm, sup);
    chk(bus_addr == ea, "R4/R6 beat address", bus_addr, ea);
    if (wr) begin
      chk(bus_doe == 1'b1, "R7 write enable", bus_doe, 1);
      chk(bus_dout == wd[b*PW +: PW], "R7 write data", bus_dout, wd[b*PW +: PW]);
    end else begin
      chk(!bus_doe && bus_rd, "R7 read direction", {bus_doe, bus_rd}, 2'b01);
    end
  endtask

  task automatic run_burst(input bit wr, input bit sup, input int nreq, input logic [1:0] a0,
                           input logic [63:0] wv, input logic [LW-1:0] wd, input logic [PW-1:0] seed);
    int n;
    logic [LW-1:0] e;
    n = clampn(nreq);
    e = '0;
    if (!wr) for (int b = 0; b < n; b++) e[b*PW +: PW] = rdv(b, seed);
    exp_q.push_back(e);
    @(negedge clk);
    req_write = wr; req_super = sup; req_beats = 5'(nreq); req_addr = a0; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_ts && bus_act, "R1 start strobe", {bus_ts, bus_act}, 2'b11);
    chk(!bus_tm, "R2 marker low in start clock", bus_tm, 0);
    chk(bus_addr == a0, "R6 start address", bus_addr, a0);
    @(posedge clk);
    for (int b = 0; b < n; b++) begin
      logic [1:0] ea;
      ea = 2'(a0 + 2'(b));
      for (int w = 0; w < int'(wv[b*4 +: 4]); w++) begin
        @(negedge clk); beat_chk(wr, sup, ea, b, wd);
        @(posedge clk);
      end
      #1 bus_ack = 1'b1; bus_din = rdv(b, seed);
      @(negedge clk); beat_chk(wr, sup, ea, b, wd);
      @(posedge clk); #1 bus_ack = 1'b0;
      @(negedge clk); beat_chk(wr, sup, ea, b, wd);
      chk(!done, "R3 no completion one clock after ack", done, 0);
      @(posedge clk); #1 bus_din = '0;
    end
    @(negedge clk);
    chk(!bus_act && done && req_ready, "R3/R8 ends after final beat", {bus_act, done, req_ready}, 3'b011);
    @(negedge clk);
    chk(!done, "R5 done single pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] wline;
    for (int i = 0; i < 16; i++) wline[i*PW +: PW] = 16'(16'hC0DE + i * 16'h0421);
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_act && !bus_ts && !bus_doe && !done, "R10 reset state",
        {req_ready, bus_act, bus_ts, bus_doe, done}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_burst(0, 0, 2, 2'd0, 64'h0, '0, 16'h1111);                    // R3 zero wait
    run_burst(0, 1, 4, 2'd1, 64'h3120, '0, 16'h2222);                 // R4 waits
    run_burst(1, 1, 4, 2'd2, 64'h0201, wline, 16'h0);                 // R7 write
    run_burst(0, 0, 16, 2'd3, 64'h1020304010203041, '0, 16'h3333);    // R6 wrap
    run_burst(0, 1, 1, 2'd0, 64'h0, '0, 16'h4444);                    // R8 low clamp
    run_burst(1, 0, 20, 2'd1, 64'h0, wline, 16'h0);                   // R8 high clamp

    fork
      run_burst(0, 0, 3, 2'd0, 64'h111, '0, 16'h5555);
      begin
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_beats = 5'd9; req_addr = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (3) begin
      @(negedge clk);
      chk(!bus_ts && !bus_act, "R9 busy request ignored", {bus_ts, bus_act}, 2'b00);
    end

    @(negedge clk);
    req_write = 1'b1; req_super = 1'b1; req_beats = 5'd8; req_addr = 2'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    bus_ack = 1'b1;
    rst_n = 1'b0;
    #1;
    chk(!bus_act && !bus_ts && !bus_doe && !bus_tm && req_ready && !done, "R10 abandon on reset",
        {bus_act, bus_ts, bus_doe, bus_tm, req_ready, done}, 6'b000010);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_act, "R10 idle after reset with ack high", bus_act, 0);
    bus_ack = 1'b0;
    repeat (2) @(negedge clk);
    run_burst(0, 0, 2, 2'd0, 64'h20, '0, 16'h6666);                   // R10 clean restart

    chk(exp_q.size() == 0, "R5 all bursts completed", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule